// File: doc/BRIEF.md
# Configurable SPI Shift Engine

This block is the serial core of an SPI port. It moves one parallel word at a time between a buffer layer and the serial pins, in both directions at once. A single `load` strobe hands it a transmit word. A one-cycle `done` strobe marks the cycle in which the received word on `rx_word` is complete. The engine runs as a bus master, where it generates the serial clock from a two-stage divider. It can also run as a bus slave, where it follows an external clock seen through a synchroniser.

Clock idle level, clock phase, bit order and frame length (8 or 16 bits) are set by static configuration inputs. These inputs are held stable while a frame is in progress. The select pin has three roles in master mode: a general-purpose output, an automatic per-frame select, or an input that watches for a competing master. If that input is pulled low, the engine gives up the bus. A pin mode also lets the engine share a single data wire for both directions.

Top module: `spi_shift_engine`

## Requirements
- R1: While the engine is master and no frame is in progress, `sck_o` equals `cpol` (0 idles low, 1 idles high).
- R2: With H = (prescale+1)*2^rate system clocks, a master frame of N bits toggles `sck_o` exactly 2N times. The first toggle comes H cycles after the clock edge that accepts `load`, and each later toggle comes H cycles after the previous one.
- R3: With `cpha`=0 the first data bit is on the output from the accepting edge. Odd-numbered toggles sample and even-numbered toggles launch the next bit. With `cpha`=1 even-numbered toggles sample, and odd-numbered toggles from the third onward launch the next bit.
- R4: With `lsb_first`=0 bit N-1 of the word travels first. With `lsb_first`=1 bit 0 travels first. Received bits are placed in the same order.
- R5: With `wide_frame`=1, N=16. With `wide_frame`=0, N=8: only `tx_word[7:0]` is sent and `rx_word[15:8]` reads 0.
- R6: With `sel_mode`=3, `ss_o` is low from the accepting edge until H cycles after the last toggle. It rises in the same cycle as a one-cycle `done` and the fall of `busy`.
- R7: With `sel_mode` 0 or 1, `ss_oe` is high and `ss_o` follows `gpio_ss`. With `sel_mode`=2, `ss_oe` is low.
- R8: A master with `sel_mode`=2 that sees `ss_i` low (after a two-stage synchroniser) raises `mode_fault` for exactly one cycle. It then drops `is_master`, `sck_oe` and `mosi_oe`, and stays that way until `master_req` is released.
- R9: `pin_mode` 0 or 2 is two-wire: the master drives MOSI and samples MISO. `pin_mode`=1 is single-wire input: the master leaves `mosi_oe` low and samples `mosi_i`. `pin_mode`=3 is single-wire output: the master drives MOSI, samples `mosi_i`, and ignores `miso_i`.
- R10: As slave (`master_req`=0) with `ss_i` low, the engine shifts on edges of the synchronised `sck_i`. It drives `miso_o` with `miso_oe` high and pulses `done` after 2N edges. A `load` while no frame is in progress captures the next transmit word.
- R11: Clearing `en` aborts any frame: from the next cycle `busy` is low, `sck_o` is at its idle level, and no `done` follows.
- R12: A `load` while a master frame is in progress is ignored; the frame keeps sending the word it accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Engine enable; low aborts |
| master_req | input | 1 | 1 requests master role, 0 slave |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | Clock phase select |
| lsb_first | input | 1 | Bit order select |
| wide_frame | input | 1 | 1 for 16-bit frames, 0 for 8-bit |
| sel_mode | input | 2 | Select pin role (0/1 GPIO, 2 fault input, 3 automatic) |
| pin_mode | input | 2 | Data pin mode (0/2 two-wire, 1 single-wire in, 3 single-wire out) |
| prescale | input | 3 | First divider stage |
| rate | input | 4 | Power-of-two divider stage |
| gpio_ss | input | 1 | Select level in GPIO role |
| tx_word | input | 16 | Word to transmit |
| load | input | 1 | Transmit word strobe |
| rx_word | output | 16 | Received word |
| done | output | 1 | One-cycle frame complete strobe |
| busy | output | 1 | Frame in progress |
| is_master | output | 1 | Effective master role |
| mode_fault | output | 1 | One-cycle fault strobe |
| sck_i | input | 1 | Serial clock input (slave) |
| sck_o | output | 1 | Serial clock output |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | MOSI pin input |
| mosi_o | output | 1 | MOSI pin output |
| mosi_oe | output | 1 | MOSI output enable |
| miso_i | input | 1 | MISO pin input |
| miso_o | output | 1 | MISO pin output |
| miso_oe | output | 1 | MISO output enable |
| ss_i | input | 1 | Select pin input |
| ss_o | output | 1 | Select pin output |
| ss_oe | output | 1 | Select pin output enable |

## Verification
Properties are checked on every cycle. They cover the idle clock level, the bound on the divider count, the frame-step counter never passing 2N, the select line being high whenever `done` fires in automatic mode, the single-cycle fault strobe followed by loss of mastership, and the quiet state after a disable. Only the bench's scenarios can show the rest. That covers the exact toggle timing for several divider settings, the launch and sample edges for each phase, the bit order and frame length seen on the wire, the data line chosen in each pin mode, slave reception from an external clock, and the ignored mid-frame load.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
   typedef enum logic [1:0] {
      SEL_GPIO     = 2'd0,
      SEL_GPIO_ALT = 2'd1,
      SEL_FAULT    = 2'd2,
      SEL_AUTO     = 2'd3
   } sel_mode_e;

   typedef enum logic [1:0] {
      PIN_TWO_WIRE  = 2'd0,
      PIN_WIRE_IN   = 2'd1,
      PIN_TWO_ALT   = 2'd2,
      PIN_WIRE_OUT  = 2'd3
   } pin_mode_e;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
   parameter int         STAGES = 2,
   parameter logic       RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("spi_in_sync needs at least two stages");
   end

   logic [STAGES-1:0] stg;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= RST_VAL;
            else        stg[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= RST_VAL;
            else        stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_baud_gen.sv
module spi_baud_gen #(
   parameter int PRE_W  = 3,
   parameter int RATE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [PRE_W-1:0]  prescale,
   input  logic [RATE_W-1:0] rate,
   output logic              tick
);
   localparam int RATE_MAX = (1 << RATE_W) - 1;
   localparam int CNT_W    = PRE_W + RATE_MAX + 1;

   if (PRE_W < 1 || RATE_W < 1 || CNT_W > 40) begin : g_bad_div
      $error("spi_baud_gen divider fields out of range");
   end

   logic [CNT_W-1:0] half_w;
   logic [CNT_W-1:0] cnt_q;

   // half bit period in system clocks
   assign half_w = (CNT_W'(prescale) + CNT_W'(1)) << rate;
   assign tick   = run && (cnt_q == half_w - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (!run || tick) cnt_q <= '0;
      else                   cnt_q <= cnt_q + CNT_W'(1);
   end

   // R2: the count never passes the half-bit length while the divisors hold
   assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $stable(prescale) && $stable(rate)) |-> (cnt_q < half_w));
endmodule

// File: rtl/spi_sel_ctrl.sv
module spi_sel_ctrl
   import spi_eng_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       master_req,
   input  logic [1:0] sel_mode,
   input  logic       ss_i,
   input  logic       gpio_ss,
   input  logic       frame_act,
   output logic       ss_sync,
   output logic       master_eff,
   output logic       fault_pulse,
   output logic       ss_o,
   output logic       ss_oe
);
   logic fault_q;
   logic pulse_q;
   logic fault_cond;

   spi_in_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_ss_sync (
      .clk(clk), .rst_n(rst_n), .d(ss_i), .q(ss_sync)
   );

   assign fault_cond = en && master_req && !fault_q
                       && (sel_mode == SEL_FAULT) && !ss_sync;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fault_q <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         pulse_q <= fault_cond;
         if (!master_req)     fault_q <= 1'b0;
         else if (fault_cond) fault_q <= 1'b1;
      end
   end

   assign master_eff  = master_req && !fault_q;
   assign fault_pulse = pulse_q;
   assign ss_oe       = en && master_eff && (sel_mode != SEL_FAULT);
   assign ss_o        = (sel_mode == SEL_AUTO) ? !frame_act : gpio_ss;

   // R8: the fault strobe lasts one cycle
   assert_fault_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |=> !pulse_q);
   // R8: after a fault the master role is gone
   assert_fault_yield_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |-> !master_eff);
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
   import spi_eng_pkg::*;
#(
   parameter int WIDE_W      = 16,
   parameter int NARROW_W    = 8,
   parameter int PRE_W       = 3,
   parameter int RATE_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              master_req,
   input  logic              cpol,
   input  logic              cpha,
   input  logic              lsb_first,
   input  logic              wide_frame,
   input  logic [1:0]        sel_mode,
   input  logic [1:0]        pin_mode,
   input  logic [PRE_W-1:0]  prescale,
   input  logic [RATE_W-1:0] rate,
   input  logic              gpio_ss,
   input  logic [WIDE_W-1:0] tx_word,
   input  logic              load,
   output logic [WIDE_W-1:0] rx_word,
   output logic              done,
   output logic              busy,
   output logic              is_master,
   output logic              mode_fault,
   input  logic              sck_i,
   output logic              sck_o,
   output logic              sck_oe,
   input  logic              mosi_i,
   output logic              mosi_o,
   output logic              mosi_oe,
   input  logic              miso_i,
   output logic              miso_o,
   output logic              miso_oe,
   input  logic              ss_i,
   output logic              ss_o,
   output logic              ss_oe
);
   localparam int TW = $clog2(2*WIDE_W + 1);
   localparam int IW = $clog2(WIDE_W);

   if (NARROW_W < 2 || NARROW_W >= WIDE_W || TW <= IW) begin : g_bad_width
      $error("spi_shift_engine frame widths out of range");
   end

   logic              active_q, sck_q, done_q;
   logic [TW-1:0]     t_q, t_inc, two_n, b_raw;
   logic [IW-1:0]     n_m1, b_idx, tx_pos, s_idx, rx_pos;
   logic [WIDE_W-1:0] tx_q, rx_q, rx_nxt;
   logic              tick, ss_sync, master_eff, sck_s, sck_d, sck_edge;
   logic              slave_sel, samp, din, out_bit, drive_ok;

   spi_baud_gen #(.PRE_W(PRE_W), .RATE_W(RATE_W)) i_baud (
      .clk(clk), .rst_n(rst_n), .run(active_q),
      .prescale(prescale), .rate(rate), .tick(tick)
   );

   spi_sel_ctrl #(.SYNC_STAGES(SYNC_STAGES)) i_sel (
      .clk(clk), .rst_n(rst_n), .en(en), .master_req(master_req),
      .sel_mode(sel_mode), .ss_i(ss_i), .gpio_ss(gpio_ss),
      .frame_act(active_q), .ss_sync(ss_sync), .master_eff(master_eff),
      .fault_pulse(mode_fault), .ss_o(ss_o), .ss_oe(ss_oe)
   );

   spi_in_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sck_sync (
      .clk(clk), .rst_n(rst_n), .d(sck_i), .q(sck_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_d <= 1'b0;
      else        sck_d <= sck_s;
   end
   assign sck_edge = sck_s ^ sck_d;

   // frame geometry
   assign two_n = wide_frame ? TW'(2*WIDE_W)  : TW'(2*NARROW_W);
   assign n_m1  = wide_frame ? IW'(WIDE_W-1)  : IW'(NARROW_W-1);
   assign t_inc = t_q + TW'(1);

   // launch pointer: which bit is on the wire at step t_q
   assign b_raw  = cpha ? ((t_q == '0) ? '0 : (t_q - TW'(1)) >> 1) : (t_q >> 1);
   assign b_idx  = (b_raw > TW'(n_m1)) ? n_m1 : b_raw[IW-1:0];
   assign tx_pos = lsb_first ? b_idx : (n_m1 - b_idx);
   assign out_bit = tx_q[tx_pos];

   // sample point: the step that is about to complete
   assign samp   = t_inc[0] ^ cpha;
   assign s_idx  = t_q[IW:1];
   assign rx_pos = lsb_first ? s_idx : (n_m1 - s_idx);

   assign din = master_eff ? (pin_mode[0] ? mosi_i : miso_i)
                           : (pin_mode[0] ? miso_i : mosi_i);

   always_comb begin
      rx_nxt = (t_q == '0) ? '0 : rx_q;
      if (samp) rx_nxt[rx_pos] = din;
   end

   assign slave_sel = en && !master_eff && !ss_sync;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         sck_q    <= 1'b0;
         done_q   <= 1'b0;
         t_q      <= '0;
         tx_q     <= '0;
         rx_q     <= '0;
      end else begin
         done_q <= 1'b0;
         if (!en) begin
            active_q <= 1'b0;
            sck_q    <= 1'b0;
            t_q      <= '0;
         end else if (master_eff) begin
            if (!active_q) begin
               sck_q <= 1'b0;
               t_q   <= '0;
               if (load) begin
                  active_q <= 1'b1;
                  tx_q     <= tx_word;
               end
            end else if (tick) begin
               if (t_q == two_n) begin
                  active_q <= 1'b0;
                  t_q      <= '0;
                  done_q   <= 1'b1;
               end else begin
                  t_q   <= t_inc;
                  sck_q <= !sck_q;
                  rx_q  <= rx_nxt;
               end
            end
         end else begin
            active_q <= 1'b0;
            sck_q    <= 1'b0;
            if (!slave_sel) begin
               t_q <= '0;
            end else if (sck_edge) begin
               rx_q <= rx_nxt;
               if (t_inc == two_n) begin
                  t_q    <= '0;
                  done_q <= 1'b1;
               end else begin
                  t_q <= t_inc;
               end
            end
            if (load && (t_q == '0)) tx_q <= tx_word;
         end
      end
   end

   assign drive_ok  = (pin_mode != PIN_WIRE_IN);
   assign sck_o     = cpol ^ sck_q;
   assign sck_oe    = en && master_eff;
   assign mosi_o    = out_bit;
   assign mosi_oe   = en && master_eff && drive_ok;
   assign miso_o    = out_bit;
   assign miso_oe   = slave_sel && drive_ok;
   assign rx_word   = rx_q;
   assign done      = done_q;
   assign busy      = active_q || (t_q != '0);
   assign is_master = master_eff;

   assert_sck_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (master_eff && !busy) |-> (sck_o == cpol));

   assert_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!busy && !done));

   assert_step_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $stable(wide_frame)) |-> (t_q <= two_n));

   assert_done_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && master_eff && (sel_mode == SEL_AUTO)) |-> ss_o);
endmodule

// File: tb/test_spi_shift_engine.sv
module test_spi_shift_engine;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic        en, master_req, cpol, cpha, lsb_first, wide_frame;
   logic [1:0]  sel_mode, pin_mode;
   logic [2:0]  prescale;
   logic [3:0]  rate;
   logic        gpio_ss, load;
   logic [15:0] tx_word, rx_word;
   logic        done, busy, is_master, mode_fault;
   logic        sck_i, sck_o, sck_oe, mosi_i, mosi_o, mosi_oe;
   logic        miso_i, miso_o, miso_oe, ss_i, ss_o, ss_oe;
   logic        lb, mosi_drv, miso_drv;

   assign miso_i = lb ? mosi_o : miso_drv;
   assign mosi_i = mosi_drv;

   spi_shift_engine i_spi_shift_engine (
      .clk(clk), .rst_n(rst_n), .en(en), .master_req(master_req),
      .cpol(cpol), .cpha(cpha), .lsb_first(lsb_first), .wide_frame(wide_frame),
      .sel_mode(sel_mode), .pin_mode(pin_mode), .prescale(prescale), .rate(rate),
      .gpio_ss(gpio_ss), .tx_word(tx_word), .load(load), .rx_word(rx_word),
      .done(done), .busy(busy), .is_master(is_master), .mode_fault(mode_fault),
      .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .mosi_i(mosi_i),
      .mosi_o(mosi_o), .mosi_oe(mosi_oe), .miso_i(miso_i), .miso_o(miso_o),
      .miso_oe(miso_oe), .ss_i(ss_i), .ss_o(ss_o), .ss_oe(ss_oe)
   );

   int tests = 0;
   int fails = 0;
   int done_cnt = 0;
   int cyc = 0;
   bit finished = 0;

   always @(posedge clk) begin
      cyc++;
      if (done) done_cnt++;
      if (cyc > 150000 && !finished) begin
         finished = 1;
         tests++; fails++;
         $display("FAIL watchdog: all requirements, actual cycle %0d expected < 150000", cyc);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic int bptr(input logic pha, input int c, input int n);
      int b;
      if (!pha) b = c / 2;
      else      b = (c == 0) ? 0 : (c - 1) / 2;
      if (b > n - 1) b = n - 1;
      return b;
   endfunction

   function automatic int bpos(input logic lsb, input int k, input int n);
      return lsb ? k : n - 1 - k;
   endfunction

   // behavioural model of one master frame, compared every cycle
   task automatic run_master(input logic pol, pha, lsb, wd, input int p, r,
                             input logic [15:0] tx, input logic [15:0] exp_rx,
                             input logic exp_oe, input string tag);
      int n = wd ? 16 : 8;
      int h = (p + 1) << r;
      int last = (2*n + 1) * h;
      int bad = 0;
      logic [5:0] act_v, exp_v, bad_act, bad_exp;
      bad_act = '0; bad_exp = '0;
      @(negedge clk);
      cpol = pol; cpha = pha; lsb_first = lsb; wide_frame = wd;
      prescale = 3'(p); rate = 4'(r);
      @(negedge clk);
      tx_word = tx; load = 1'b1;
      @(negedge clk);
      load = 1'b0;
      for (int j = 0; j <= last; j++) begin
         int c = j / h;
         if (c > 2*n) c = 2*n;
         act_v = {sck_o, mosi_o, ss_o, busy, done, mosi_oe};
         if (j < last)
            exp_v = {pol ^ c[0], tx[bpos(lsb, bptr(pha, c, n), n)], 1'b0, 1'b1, 1'b0, exp_oe};
         else
            exp_v = {pol, act_v[4], 1'b1, 1'b0, 1'b1, exp_oe};
         if (act_v != exp_v && bad == 0) begin
            bad_act = act_v; bad_exp = exp_v;
            $display("  mismatch at cycle %0d of %s frame", j, tag);
         end
         if (act_v != exp_v) bad++;
         // R12: a load in the middle of the frame must be ignored
         if (j == 5) begin tx_word = ~tx; load = 1'b1; end
         else load = 1'b0;
         @(negedge clk);
      end
      load = 1'b0;
      check(bad == 0, {"R2 R3 R4 R6 R9 R12 waveform ", tag}, int'(bad_act), int'(bad_exp));
      check(rx_word == exp_rx, {"R4 R5 R9 received word ", tag}, int'(rx_word), int'(exp_rx));
   endtask

   task automatic run_slave(input logic pol, pha, lsb, wd,
                            input logic [15:0] tx, input logic [15:0] rxd, input string tag);
      int n = wd ? 16 : 8;
      int bad = 0;
      int base;
      logic [15:0] mask;
      mask = wd ? 16'hFFFF : 16'h00FF;
      @(negedge clk);
      master_req = 1'b0; cpol = pol; cpha = pha; lsb_first = lsb; wide_frame = wd;
      ss_i = 1'b1; sck_i = pol; lb = 1'b0;
      repeat (4) @(negedge clk);
      tx_word = tx; load = 1'b1;
      @(negedge clk);
      load = 1'b0; ss_i = 1'b0;
      repeat (6) @(negedge clk);
      base = done_cnt;
      for (int k = 0; k < n; k++) begin
         if (!pha) begin
            mosi_drv = rxd[bpos(lsb, k, n)];
            repeat (8) @(negedge clk);
            if (miso_o != tx[bpos(lsb, k, n)] || !miso_oe) bad++;
            sck_i = ~sck_i;
            repeat (8) @(negedge clk);
            sck_i = ~sck_i;
         end else begin
            sck_i = ~sck_i;
            repeat (4) @(negedge clk);
            mosi_drv = rxd[bpos(lsb, k, n)];
            repeat (4) @(negedge clk);
            if (miso_o != tx[bpos(lsb, k, n)] || !miso_oe) bad++;
            sck_i = ~sck_i;
            repeat (8) @(negedge clk);
         end
      end
      repeat (8) @(negedge clk);
      check(bad == 0, {"R10 slave output bits ", tag}, bad, 0);
      check(rx_word == (rxd & mask), {"R10 slave received word ", tag}, int'(rx_word), int'(rxd & mask));
      check(done_cnt - base == 1, {"R10 slave done count ", tag}, done_cnt - base, 1);
      ss_i = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      int base;
      int pulses;
      en = 1'b1; master_req = 1'b1; cpol = 1'b0; cpha = 1'b0; lsb_first = 1'b0;
      wide_frame = 1'b0; sel_mode = 2'd3; pin_mode = 2'd0; prescale = 3'd0; rate = 4'd0;
      gpio_ss = 1'b1; load = 1'b0; tx_word = '0; sck_i = 1'b0; ss_i = 1'b1;
      lb = 1'b1; mosi_drv = 1'b0; miso_drv = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state, R1 idle clock, R6 select high
      check(!busy && !done && !mode_fault, "R11 reset quiet", {busy, done, mode_fault}, 0);
      check(sck_o == 1'b0 && ss_o == 1'b1, "R1 R6 reset pins", {sck_o, ss_o}, 2'b01);

      // master loopback frames over varied configurations
      run_master(1'b0, 1'b0, 1'b0, 1'b0, 0, 1, 16'h00A5, 16'h00A5, 1'b1, "p0 msb 8b");
      run_master(1'b1, 1'b1, 1'b1, 1'b1, 2, 0, 16'h3C96, 16'h3C96, 1'b1, "p3 lsb 16b");
      run_master(1'b0, 1'b1, 1'b0, 1'b1, 1, 1, 16'h8001, 16'h8001, 1'b1, "p1 msb 16b");
      run_master(1'b1, 1'b0, 1'b1, 1'b0, 0, 0, 16'h004E, 16'h004E, 1'b1, "p2 lsb 8b h1");
      run_master(1'b0, 1'b0, 1'b0, 1'b0, 0, 1, 16'hFF12, 16'h0012, 1'b1, "R5 narrow upper");
      check(sck_o == cpol, "R1 idle after frame", sck_o, cpol);

      // R9 single-wire input: no drive, sample mosi_i
      lb = 1'b0; pin_mode = 2'd1; mosi_drv = 1'b1; miso_drv = 1'b0;
      run_master(1'b0, 1'b0, 1'b0, 1'b0, 0, 1, 16'h0033, 16'h00FF, 1'b0, "R9 wire in");
      // R9 single-wire output: drive, sample mosi_i, ignore miso_i
      pin_mode = 2'd3; mosi_drv = 1'b0; miso_drv = 1'b1;
      run_master(1'b0, 1'b1, 1'b0, 1'b0, 0, 1, 16'h00C7, 16'h0000, 1'b1, "R9 wire out");
      pin_mode = 2'd0; lb = 1'b1;

      // R7 select pin roles
      @(negedge clk); sel_mode = 2'd0; gpio_ss = 1'b0;
      @(negedge clk);
      check(ss_oe && !ss_o, "R7 gpio low", {ss_oe, ss_o}, 2'b10);
      gpio_ss = 1'b1; sel_mode = 2'd1;
      @(negedge clk);
      check(ss_oe && ss_o, "R7 gpio high alt", {ss_oe, ss_o}, 2'b11);
      sel_mode = 2'd2;
      @(negedge clk);
      check(!ss_oe && is_master, "R7 fault role input", {ss_oe, is_master}, 2'b01);

      // R8 competing master
      ss_i = 1'b0; pulses = 0;
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         if (mode_fault) pulses++;
      end
      check(pulses == 1, "R8 fault pulse count", pulses, 1);
      check(!is_master && !sck_oe && !mosi_oe, "R8 outputs released",
            {is_master, sck_oe, mosi_oe}, 0);
      master_req = 1'b0; ss_i = 1'b1;
      repeat (4) @(negedge clk);
      master_req = 1'b1; sel_mode = 2'd3;
      @(negedge clk);
      check(is_master && sck_oe, "R8 master restored", {is_master, sck_oe}, 2'b11);

      // R11 abort mid-frame
      cpol = 1'b1; cpha = 1'b0; wide_frame = 1'b1; prescale = 3'd1; rate = 4'd1;
      @(negedge clk);
      tx_word = 16'h5AA5; load = 1'b1;
      @(negedge clk);
      load = 1'b0;
      repeat (20) @(negedge clk);
      base = done_cnt;
      en = 1'b0;
      @(negedge clk);
      check(!busy && sck_o == 1'b1 && ss_o == 1'b1, "R11 abort state",
            {busy, sck_o, ss_o}, 3'b011);
      repeat (10) @(negedge clk);
      check(done_cnt == base, "R11 no done after abort", done_cnt - base, 0);
      en = 1'b1;
      @(negedge clk);

      // R10 slave reception
      run_slave(1'b0, 1'b0, 1'b0, 1'b0, 16'h00C3, 16'h005A, "p0 msb 8b");
      run_slave(1'b1, 1'b1, 1'b1, 1'b1, 16'h1234, 16'hBEEF, "p3 lsb 16b");

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule